// File: doc/BRIEF.md
# Byte-Counting LCD Video Capture Decoder

This block listens to a monochrome LCD video stream that carries only an 8-bit pixel bus, a byte strobe and a frame pulse. There is no line strobe, so rows are rebuilt by counting bytes. Each byte holds eight pixels, and bit 7 is the leftmost of the eight. Both strobes are asynchronous to the system clock. They are synchronised with two flops each and then edge-detected. A byte is taken on each falling edge of the byte strobe and written to a frame store through a simple address/data write port.

A rising edge of the frame pulse starts a new frame. At that edge the block also judges the frame that just ended: a frame holding exactly `MAX_ROWS * BYTES_PER_ROW` bytes gives a `frame_done` pulse, and any other count gives a `frame_error` pulse. Bytes beyond the store capacity are not written and set a sticky `overflow` flag. Only a reset clears that flag.

Top module: `lcd_capture_decoder`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `wr_en`, `frame_done`, `frame_error` and `overflow` are 0.
- R2: Bytes strobed before the first frame-pulse rising edge after reset are not written and set no flag. That first rising edge itself raises neither `frame_done` nor `frame_error`.
- R3: A falling edge of `byte_clk` inside a frame gives exactly one `wr_en` pulse of one cycle. `wr_en` is high in the third clock cycle after the falling edge is applied at the pin. `wr_data` equals the 8-bit bus unchanged, with bit 7 the leftmost pixel.
- R4: After each frame-pulse rising edge, accepted bytes get consecutive addresses starting at 0. The address is row*BYTES_PER_ROW+column, and the column wraps to 0 and advances the row after BYTES_PER_ROW bytes.
- R5: At a frame-pulse rising edge, `frame_done` pulses for one cycle when the ending frame held exactly MAX_ROWS*BYTES_PER_ROW bytes.
- R6: At a frame-pulse rising edge, `frame_error` pulses for one cycle when the ending frame held any other byte count (zero, short or long). `frame_done` and `frame_error` are never high together.
- R7: Bytes past MAX_ROWS rows in a frame are not written and make the frame fail. They set `overflow`, which stays 1 until reset. Write addresses always stay below MAX_ROWS*BYTES_PER_ROW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| vid_data | input | 8 | Pixel byte bus, bit 7 leftmost pixel |
| byte_clk | input | 1 | Asynchronous byte strobe, data taken on falling edge |
| frame_clk | input | 1 | Asynchronous frame pulse, rising edge starts a frame |
| wr_en | output | 1 | Frame store write strobe |
| wr_addr | output | $clog2(MAX_ROWS*BYTES_PER_ROW) | Frame store byte address |
| wr_data | output | 8 | Byte to store |
| frame_done | output | 1 | One-cycle pulse: previous frame complete |
| frame_error | output | 1 | One-cycle pulse: previous frame had a wrong byte count |
| overflow | output | 1 | Sticky: a byte arrived beyond capacity |

## Verification
The assertions check on every cycle that writes and frame flags are single-cycle pulses and that the two flags never coincide. They also check that no write address reaches the capacity and that `overflow` never falls outside reset. The bench scenarios are the only way to show the rest: which byte counts count as complete, the exact address sequence across row wraps and frame restarts, the bytes ignored before the first frame pulse, and the three-cycle strobe-to-write latency. Each vector gives a byte count and the flags expected after the next frame pulse, and the bench checks every captured write against its expected address and data.

// File: rtl/lcd_capture_decoder.sv
module lcd_capture_decoder #(
  parameter int BYTES_PER_ROW = 80,
  parameter int MAX_ROWS      = 200
) (
  input  logic                                        clk,
  input  logic                                        rst,
  input  logic [7:0]                                  vid_data,
  input  logic                                        byte_clk,
  input  logic                                        frame_clk,
  output logic                                        wr_en,
  output logic [$clog2(MAX_ROWS*BYTES_PER_ROW)-1:0]   wr_addr,
  output logic [7:0]                                  wr_data,
  output logic                                        frame_done,
  output logic                                        frame_error,
  output logic                                        overflow
);
  localparam int CAP    = MAX_ROWS * BYTES_PER_ROW;
  localparam int ADDR_W = $clog2(CAP);
  localparam int CNT_W  = $clog2(CAP + 1);
  localparam int COL_W  = (BYTES_PER_ROW > 1) ? $clog2(BYTES_PER_ROW) : 1;
  localparam int ROW_W  = $clog2(MAX_ROWS + 1);

  logic       bc_m, bc_s, bc_p;
  logic       fc_m, fc_s, fc_p;
  logic [7:0] d_m, d_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      {bc_m, bc_s, bc_p} <= '0;
      {fc_m, fc_s, fc_p} <= '0;
      d_m <= '0;
      d_s <= '0;
    end else begin
      bc_m <= byte_clk;  bc_s <= bc_m;  bc_p <= bc_s;
      fc_m <= frame_clk; fc_s <= fc_m;  fc_p <= fc_s;
      d_m  <= vid_data;  d_s  <= d_m;
    end
  end

  wire byte_fall  = bc_p & ~bc_s;
  wire frame_rise = fc_s & ~fc_p;

  logic             armed, frame_ovf;
  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;
  logic [CNT_W-1:0] addr;

  logic [COL_W-1:0] col0, col_n;
  logic [ROW_W-1:0] row0, row_n;
  logic [CNT_W-1:0] addr0;
  logic             ovf0, live, accept, drop;

  always_comb begin
    col0   = frame_rise ? '0 : col;
    row0   = frame_rise ? '0 : row;
    addr0  = frame_rise ? '0 : addr;
    ovf0   = frame_rise ? 1'b0 : frame_ovf;
    live   = byte_fall & (armed | frame_rise);
    accept = live & (row0 < ROW_W'(MAX_ROWS));
    drop   = live & ~accept;
    col_n  = col0;
    row_n  = row0;
    if (accept) begin
      if (col0 == COL_W'(BYTES_PER_ROW - 1)) begin
        col_n = '0;
        row_n = row0 + 1'b1;
      end else begin
        col_n = col0 + 1'b1;
      end
    end
  end

  wire frame_good = (row == ROW_W'(MAX_ROWS)) && (col == '0) && !frame_ovf;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed       <= 1'b0;
      frame_ovf   <= 1'b0;
      col         <= '0;
      row         <= '0;
      addr        <= '0;
      wr_en       <= 1'b0;
      wr_addr     <= '0;
      wr_data     <= '0;
      frame_done  <= 1'b0;
      frame_error <= 1'b0;
      overflow    <= 1'b0;
    end else begin
      armed       <= armed | frame_rise;
      col         <= col_n;
      row         <= row_n;
      addr        <= accept ? addr0 + 1'b1 : addr0;
      frame_ovf   <= ovf0 | drop;
      overflow    <= overflow | drop;
      wr_en       <= accept;
      if (accept) begin
        wr_addr <= addr0[ADDR_W-1:0];
        wr_data <= d_s;
      end
      frame_done  <= frame_rise & armed & frame_good;
      frame_error <= frame_rise & armed & ~frame_good;
    end
  end
endmodule

// File: rtl/lcd_capture_checker.sv
module lcd_capture_checker #(
  parameter int CAP    = 16000,
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              frame_done,
  input logic              frame_error,
  input logic              overflow
);
  assert_wr_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(frame_done && frame_error));

  assert_error_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    frame_error |=> !frame_error);

  assert_addr_in_store_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (int'(wr_addr) < CAP));

  assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
endmodule

bind lcd_capture_decoder lcd_capture_checker #(.CAP(CAP), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_lcd_capture_decoder.sv
`timescale 1ns/1ps
module sim_lcd_capture_decoder;
  localparam int BPR = 4;
  localparam int ROWS = 3;
  localparam int CAP = BPR * ROWS;
  localparam int AW = $clog2(CAP);

  logic clk = 0, rst = 1;
  logic [7:0] vid_data = '0;
  logic byte_clk = 0, frame_clk = 0;
  logic wr_en, frame_done, frame_error, overflow;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_data;

  always #10 clk = ~clk;

  lcd_capture_decoder #(.BYTES_PER_ROW(BPR), .MAX_ROWS(ROWS)) u0 (
    .clk(clk), .rst(rst), .vid_data(vid_data), .byte_clk(byte_clk),
    .frame_clk(frame_clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_done(frame_done), .frame_error(frame_error), .overflow(overflow));

  int checks = 0, failures = 0;
  bit finished = 0;

  int nw = 0, ndone = 0, nerr = 0;
  logic [AW-1:0] wa [128];
  logic [7:0]    wd [128];
  always @(posedge clk) begin
    if (wr_en && nw < 128) begin wa[nw] <= wr_addr; wd[nw] <= wr_data; end
    if (wr_en) nw <= nw + 1;
    if (frame_done) ndone <= ndone + 1;
    if (frame_error) nerr <= nerr + 1;
  end

  // {byte count, expect done, expect error, expect overflow}
  localparam logic [10:0] VEC [5] = '{
    {8'd12, 1'b1, 1'b0, 1'b0},
    {8'd5,  1'b0, 1'b1, 1'b0},
    {8'd14, 1'b0, 1'b1, 1'b1},
    {8'd0,  1'b0, 1'b1, 1'b1},
    {8'd12, 1'b1, 1'b0, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] d);
    @(negedge clk); vid_data = d; byte_clk = 1;
    repeat (3) @(negedge clk);
    byte_clk = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic frame_pulse();
    @(negedge clk); frame_clk = 1;
    repeat (3) @(negedge clk);
    frame_clk = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!wr_en && !frame_done && !frame_error && !overflow, "R1 reset outputs", 1, 0);
    rst = 0;
    @(negedge clk);
    chk({wr_en, frame_done, frame_error, overflow} == 4'b0, "R1 after reset",
        {wr_en, frame_done, frame_error, overflow}, 0);

    send_byte(8'h11);
    send_byte(8'h22);
    chk(nw == 0, "R2 no writes before first frame pulse", nw, 0);
    chk(overflow == 0, "R2 no overflow before first frame pulse", overflow, 0);
    frame_pulse();
    chk(ndone + nerr == 0, "R2 first frame pulse raises no flag", ndone + nerr, 0);

    for (int v = 0; v < 5; v++) begin
      int n, base, d0, e0, expw;
      n = int'(VEC[v][10:3]);
      base = nw; d0 = ndone; e0 = nerr;
      expw = (n < CAP) ? n : CAP;
      for (int i = 0; i < n; i++) send_byte(8'((v * 37 + i * 13) ^ 8'hA5));
      chk(nw - base == expw, "R7 write count capped at capacity", nw - base, expw);
      for (int i = 0; i < expw; i++) begin
        chk(int'(wa[base + i]) == i, "R4 address sequence", int'(wa[base + i]), i);
        chk(wd[base + i] == 8'((v * 37 + i * 13) ^ 8'hA5), "R3 data passthrough",
            wd[base + i], 8'((v * 37 + i * 13) ^ 8'hA5));
      end
      frame_pulse();
      chk(ndone - d0 == int'(VEC[v][2]), "R5 frame_done count", ndone - d0, int'(VEC[v][2]));
      chk(nerr - e0 == int'(VEC[v][1]), "R6 frame_error count", nerr - e0, int'(VEC[v][1]));
      chk(overflow == VEC[v][0], "R7 overflow flag", overflow, VEC[v][0]);
    end

    // R3 latency: write strobe in the third cycle after the falling edge
    @(negedge clk); vid_data = 8'h81; byte_clk = 1;
    repeat (3) @(negedge clk);
    byte_clk = 0;
    @(negedge clk);
    @(negedge clk);
    chk(wr_en == 0, "R3 no write two cycles after fall", wr_en, 0);
    @(negedge clk);
    chk(wr_en == 1, "R3 write three cycles after fall", wr_en, 1);
    chk(wr_addr == 0 && wr_data == 8'h81, "R3 first byte of frame, bit7 leftmost",
        wr_data, 8'h81);
    @(negedge clk);
    chk(wr_en == 0, "R3 single-cycle write", wr_en, 0);

    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(overflow == 0, "R7 overflow cleared only by reset", overflow, 0);
    chk(wr_en == 0 && frame_done == 0 && frame_error == 0, "R1 outputs after second reset", 1, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R3 watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule